// File: doc/BRIEF.md
# Timer capture/compare channel

This block is one channel of a timer with a shared 16-bit up-counter. The counter value comes in on a port. Depending on the timer's operating mode, the channel acts as a compare register or as a capture register. In compare modes, software writes a CPU-side register. That value is moved into a buffer register, and the buffer is what the running count is compared against. On equality the channel raises a one-cycle interrupt request, and it can toggle its output pin.

Some modes move a written value into the buffer at once. The batch modes hold the write back until the counter wraps to zero, so a new period or duty value never takes effect in the middle of a cycle. In the capture modes, the channel synchronises an external input and detects a selectable edge on it. On that edge it latches the current count into the CPU-side register. In the pulse-width mode it also asks the counter to clear.

Top module: `cc_channel`

## Requirements
- R1: After reset, `rd_data_o`, `match_irq_o`, `pin_o`, `clr_req_o`, the CPU register and the buffer are all zero.
- R2: A write (`wr_en_i`) updates the CPU register at the next edge, in every mode and while the counter runs. `rd_en_i` loads the CPU register into `rd_data_o`, visible the cycle after. Otherwise `rd_data_o` holds.
- R3: The immediate-load modes are interval 0, event counter 1, one-shot 3 and free-running compare 5. In these modes a write also reaches the buffer at the same edge.
- R4: The batch modes are trigger pulse 2 and PWM 4. In these modes the buffer changes only at an edge where `cnt_zero_i` is high and a write is pending. It then takes the CPU register value held before that edge, and the pending flag clears. A write in that same cycle becomes pending again.
- R5: In modes 0 to 5, `cnt_i` equal to the buffer in a cycle raises `match_irq_o` for exactly the next cycle.
- R6: `pin_o` inverts in the same cycle that `match_irq_o` rises, but only if `out_en_i` was high in the matching cycle. Otherwise the pin holds.
- R7: `edge_sel_i` selects the valid edge of `cap_i`: 0 none, 1 rising, 2 falling, 3 both. `cap_i` passes through two flops before edge detection. An input change sampled at edge k is therefore captured at edge k+2.
- R8: The capture modes are free-running capture 6 and pulse-width 7. In these modes a valid edge stores the `cnt_i` of the detection cycle into the CPU register, and `match_irq_o` stays low.
- R9: In mode 7, every capture raises `clr_req_o` for exactly the next cycle. `clr_req_o` is never raised in other modes.
- R10: A read in the same cycle as a capture returns the value held before the capture. The new value is returned by a read one cycle later.
- R11: When a capture and a write fall in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operating mode, codes 0 to 7 as in R3, R4, R8 |
| cnt_i | input | 16 | Shared counter value |
| cnt_zero_i | input | 1 | Counter clears or reloads to zero this cycle |
| wr_en_i | input | 1 | CPU write strobe |
| wr_data_i | input | 16 | CPU write data |
| rd_en_i | input | 1 | CPU read strobe |
| rd_data_o | output | 16 | Read data, valid the cycle after rd_en_i |
| out_en_i | input | 1 | Output pin toggle enable |
| edge_sel_i | input | 2 | Capture edge select |
| cap_i | input | 1 | Asynchronous capture trigger input |
| match_irq_o | output | 1 | Compare-match interrupt request pulse |
| pin_o | output | 1 | Channel output pin |
| clr_req_o | output | 1 | Counter clear request pulse |

## Verification
Suppose the buffer or the pending flag takes a wrong value. The interrupt then lands on the wrong count, and the error appears at `match_irq_o` and `pin_o` within one counter period. A wrong pending flag in a batch mode shows up no later than the next counter wrap. A fault in the synchroniser or the edge selection moves the capture by whole cycles or drops it entirely. The bench reads the register back every cycle, so such a fault shows at `rd_data_o` one cycle after the expected capture, and in pulse-width mode also at `clr_req_o`. The bench compares all outputs each cycle against a behavioural model, so the first wrong cycle is reported.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [2:0] {
        MD_INTERVAL    = 3'd0,
        MD_EVENT       = 3'd1,
        MD_TRIGPULSE   = 3'd2,
        MD_ONESHOT     = 3'd3,
        MD_PWM         = 3'd4,
        MD_FREERUN_CMP = 3'd5,
        MD_FREERUN_CAP = 3'd6,
        MD_PULSEW      = 3'd7
    } cc_mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } cc_edge_e;

    function automatic logic mode_is_batch(cc_mode_e m);
        return (m == MD_TRIGPULSE) || (m == MD_PWM);
    endfunction

    function automatic logic mode_is_capture(cc_mode_e m);
        return (m == MD_FREERUN_CAP) || (m == MD_PULSEW);
    endfunction

endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge
    import cc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cap_i,
    input  cc_edge_e edge_sel_i,
    output logic     edge_o
);

    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     rise, fall;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], cap_i};
        rise    = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
        fall    = ~st_q.sh[STAGES-1] & st_q.sh[STAGES];
        unique case (edge_sel_i)
            EDGE_RISE: edge_o = rise;
            EDGE_FALL: edge_o = fall;
            EDGE_BOTH: edge_o = rise | fall;
            default:   edge_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: selecting no edge never yields a capture event
    a_r7_none_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == EDGE_NONE) |-> !edge_o);

endmodule

// File: rtl/cc_buffer.sv
module cc_buffer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         batch_i,
    input  logic         capmode_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         cap_fire_i,
    input  logic [W-1:0] cnt_i,
    input  logic         zero_i,
    input  logic         rd_en_i,
    output logic [W-1:0] rd_data_o,
    output logic [W-1:0] buf_o
);

    typedef struct packed {
        logic [W-1:0] cpu;
        logic [W-1:0] bufr;
        logic         pend;
        logic [W-1:0] rd;
    } buf_st_t;

    buf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en_i) st_d.rd = st_q.cpu;
        if (cap_fire_i)   st_d.cpu = cnt_i;
        else if (wr_en_i) st_d.cpu = wr_data_i;
        if (capmode_i) begin
            st_d.pend = 1'b0;
        end else if (batch_i) begin
            if (zero_i && st_q.pend) begin
                st_d.bufr = st_q.cpu;
                st_d.pend = wr_en_i;
            end else begin
                st_d.pend = st_q.pend | wr_en_i;
            end
        end else begin
            st_d.pend = 1'b0;
            if (wr_en_i) st_d.bufr = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.rd;
    assign buf_o     = st_q.bufr;

    // R4: outside the wrap cycle the buffer is frozen in batch modes
    a_r4_batch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (batch_i && !capmode_i && !zero_i) |=> $stable(st_q.bufr));

    // R11: a capture overrides a simultaneous write
    a_r11_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_fire_i && wr_en_i) |=> (st_q.cpu == $past(cnt_i)));

endmodule

// File: rtl/cc_compare.sv
module cc_compare #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] buf_i,
    input  logic         out_en_i,
    output logic         irq_o,
    output logic         pin_o
);

    typedef struct packed {
        logic irq;
        logic pin;
    } cmp_st_t;

    cmp_st_t st_d, st_q;
    logic    hit;

    always_comb begin
        st_d     = st_q;
        hit      = en_i && (cnt_i == buf_i);
        st_d.irq = hit;
        if (hit && out_en_i) st_d.pin = ~st_q.pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;
    assign pin_o = st_q.pin;

    // R6: the pin moves only together with a match request
    a_r6_pin_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.pin) |-> st_q.irq);

    // R6: a disabled output never toggles
    a_r6_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |=> $stable(st_q.pin));

endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode_i,
    input  logic [W-1:0] cnt_i,
    input  logic         cnt_zero_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_en_i,
    output logic [W-1:0] rd_data_o,
    input  logic         out_en_i,
    input  logic [1:0]   edge_sel_i,
    input  logic         cap_i,
    output logic         match_irq_o,
    output logic         pin_o,
    output logic         clr_req_o
);

    typedef struct packed {
        logic clr;
    } top_st_t;

    top_st_t      st_d, st_q;
    cc_mode_e     mode;
    logic         batch, capmode, edge_hit, cap_fire;
    logic [W-1:0] buf_val;

    assign mode    = cc_mode_e'(mode_i);
    assign batch   = mode_is_batch(mode);
    assign capmode = mode_is_capture(mode);

    cc_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap_i),
        .edge_sel_i (cc_edge_e'(edge_sel_i)),
        .edge_o     (edge_hit)
    );

    always_comb begin
        st_d     = st_q;
        cap_fire = capmode && edge_hit;
        st_d.clr = cap_fire && (mode == MD_PULSEW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr_req_o = st_q.clr;

    cc_buffer #(.W(W)) i_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .batch_i    (batch),
        .capmode_i  (capmode),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .cap_fire_i (cap_fire),
        .cnt_i      (cnt_i),
        .zero_i     (cnt_zero_i),
        .rd_en_i    (rd_en_i),
        .rd_data_o  (rd_data_o),
        .buf_o      (buf_val)
    );

    cc_compare #(.W(W)) i_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (!capmode),
        .cnt_i    (cnt_i),
        .buf_i    (buf_val),
        .out_en_i (out_en_i),
        .irq_o    (match_irq_o),
        .pin_o    (pin_o)
    );

    // R8: capture modes never raise a compare request
    a_r8_no_irq_capture: assert property (@(posedge clk) disable iff (!rst_n)
        capmode |=> !match_irq_o);

    // R9: a pulse-width capture requests a counter clear next cycle
    a_r9_clear_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && mode == MD_PULSEW) |=> clr_req_o);

    // R9: no clear request outside pulse-width mode
    a_r9_clear_only_pw: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MD_PULSEW) |=> !clr_req_o);

endmodule

// File: tb/test_cc_channel.sv
module test_cc_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic [15:0] cnt = 16'd0;
    logic        cnt_zero;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = 16'd0;
    logic        rd_en_i = 1'b0;
    logic [15:0] rd_data_o;
    logic        out_en_i = 1'b0;
    logic [1:0]  edge_sel_i = 2'd0;
    logic        cap_i = 1'b0;
    logic        match_irq_o, pin_o, clr_req_o;

    int    period = 40;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    assign cnt_zero = (cnt == 16'd0);

    cc_channel i_cc_channel (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cnt_i(cnt),
        .cnt_zero_i(cnt_zero), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .out_en_i(out_en_i),
        .edge_sel_i(edge_sel_i), .cap_i(cap_i), .match_irq_o(match_irq_o),
        .pin_o(pin_o), .clr_req_o(clr_req_o)
    );

    // counter stand-in, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n) cnt <= 16'd0;
        else if (clr_req_o || int'(cnt) >= period - 1) cnt <= 16'd0;
        else cnt <= cnt + 16'd1;
    end

    // behavioural reference model
    int m_cpu, m_buf, m_rd;
    bit m_pend, m_irq, m_pin, m_clr;
    bit hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cpu = 0; m_buf = 0; m_rd = 0;
            m_pend = 0; m_irq = 0; m_pin = 0; m_clr = 0;
            hist = '{0, 0, 0};
        end else begin
            bit newer, older, valid, is_cap, is_batch;
            int o_cpu;
            newer = hist[1];
            older = hist[2];
            case (edge_sel_i)
                2'd1: valid = newer && !older;
                2'd2: valid = !newer && older;
                2'd3: valid = newer != older;
                default: valid = 0;
            endcase
            is_cap   = (mode_i == 3'd6) || (mode_i == 3'd7);
            is_batch = (mode_i == 3'd2) || (mode_i == 3'd4);
            o_cpu = m_cpu;
            if (rd_en_i) m_rd = o_cpu;
            m_irq = !is_cap && (int'(cnt) == m_buf);
            if (m_irq && out_en_i) m_pin = !m_pin;
            m_clr = is_cap && valid && (mode_i == 3'd7);
            if (is_cap && valid) m_cpu = int'(cnt);
            else if (wr_en_i) m_cpu = int'(wr_data_i);
            if (is_cap) m_pend = 0;
            else if (is_batch) begin
                if (cnt_zero && m_pend) begin
                    m_buf = o_cpu;
                    m_pend = wr_en_i;
                end else m_pend = m_pend | wr_en_i;
            end else begin
                m_pend = 0;
                if (wr_en_i) m_buf = int'(wr_data_i);
            end
            hist.push_front(cap_i);
            void'(hist.pop_back());
        end
    end

    task automatic check(string req, string sig, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, sig, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(phase, "rd_data_o", int'(rd_data_o), m_rd);
            check(phase, "match_irq_o", int'(match_irq_o), int'(m_irq));
            check(phase, "pin_o", int'(pin_o), int'(m_pin));
            check(phase, "clr_req_o", int'(clr_req_o), int'(m_clr));
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(int v);
        @(negedge clk);
        wr_en_i = 1'b1; wr_data_i = 16'(v);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        // R1: reset values at the ports, then a read of the zeroed register
        check("R1", "rd_data_o", int'(rd_data_o), 0);
        check("R1", "match_irq_o", int'(match_irq_o), 0);
        check("R1", "pin_o", int'(pin_o), 0);
        check("R1", "clr_req_o", int'(clr_req_o), 0);
        rd_en_i = 1'b1;
        cycles(1);
        rd_en_i = 1'b0;
        cycles(1);
        check("R1", "rd_data_o", int'(rd_data_o), 0);

        // R3 R5 R6: interval mode, pin enabled
        phase = "R3/R5/R6"; mode_i = 3'd0; out_en_i = 1'b1;
        cpu_write(10);
        cycles(90);
        cpu_write(33);
        cycles(90);
        // R6: pin disabled
        phase = "R6"; out_en_i = 1'b0;
        cycles(90);
        out_en_i = 1'b1;
        // R3: free-running compare and one-shot, quick rewrites
        phase = "R3"; mode_i = 3'd5;
        cpu_write(5); cycles(7); cpu_write(20); cycles(60);
        mode_i = 3'd3; cpu_write(2); cycles(50);

        // R4: PWM, writes mid period and right at the wrap
        phase = "R4"; mode_i = 3'd4;
        cpu_write(25); cycles(10); cpu_write(12);
        cycles(90);
        wait (cnt == 16'(period - 1));
        cpu_write(30);
        cycles(90);
        mode_i = 3'd2;
        cpu_write(7); cycles(3); cpu_write(15);
        cycles(90);

        // R2 R7 R8: free-running capture, all edge selections, reading every cycle
        phase = "R2/R7/R8"; mode_i = 3'd6; rd_en_i = 1'b1;
        for (int s = 0; s < 4; s++) begin
            edge_sel_i = 2'(s);
            for (int k = 0; k < 4; k++) begin
                cycles(5 + k); cap_i = ~cap_i;
            end
            cycles(10);
        end
        // R2: writes in capture mode land in the register
        phase = "R2"; edge_sel_i = 2'd0;
        cpu_write(1234); cycles(3);

        // R9 R10: pulse width, continuous reads around each capture
        phase = "R9/R10"; mode_i = 3'd7; edge_sel_i = 2'd3; period = 200;
        for (int k = 0; k < 6; k++) begin
            cycles(11 + 3 * k); cap_i = ~cap_i;
        end
        cycles(10);

        // R11: write strobe held while captures occur
        phase = "R11"; mode_i = 3'd6; edge_sel_i = 2'd1;
        wr_en_i = 1'b1; wr_data_i = 16'hBEEF;
        for (int k = 0; k < 4; k++) begin
            cycles(6); cap_i = ~cap_i;
        end
        cycles(6);
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        cycles(4);
        finish_run();
    end

endmodule